// File: doc/BRIEF.md
# Strap-configured clock generation controller

This block keeps the settings of a clock synthesizer and turns the synthesizer output into the clock enables used by the rest of the system. The synthesizer is described by three fields: a pre-divider code, a multiplier code and a post-divider code. Each field's effective value is its code plus one. The oscillator frequency equals the reference divided by (pre+1) and multiplied by (mul+1). The output frequency equals the oscillator frequency divided by (post+1). The analog synthesizer is outside this block. It reads the three fields from output ports, and its output clock arrives here as `clk`.

Strap pins set the pre-divider and post-divider fields during power-on reset. The multiplier can only be set by software and always starts at its default. After reset, software writes two 16-bit registers through a simple write/read port. A synthesizer write is accepted only if both the divided reference and the oscillator frequency fall inside their legal ranges. These ranges are computed from a reference frequency parameter given in kHz. A rejected write raises an error flag and leaves the register unchanged.

Two power-of-two divider chains run from `clk`. The bus chain divides by 4 to 256. The processor chain divides by 2 to 128. A select bit decides whether the processor enable comes from its own chain or follows the bus enable. A change of ratio takes effect only at the end of the period in progress.

Top module: `clkcfg_ctrl`

## Requirements
- R1: While reset is active and just after it, pre_code is 7, mul_code is 60, post_code is 0, cfg_err is 0, register 1 reads 0, and cpu_en and bus_en are 0.
- R2: On the first clock edge after reset is released, pre_code is loaded with 7 XOR (NOT strap_pre) and post_code with 0 XOR (NOT strap_post). An undriven strap therefore keeps its default. Strap changes after that edge have no effect.
- R3: Register 0 (wr_sel=0) has this layout: post in bits 15:14, mul in bits 13:5 and pre in bits 4:0. A write is accepted when REF ≥ 275·(pre+1), REF ≤ 550000·(pre+1), REF·(mul+1) ≥ 110000·(pre+1) and REF·(mul+1) ≤ 550000·(pre+1), with REF in kHz. An accepted write updates the field outputs and read-back on the next cycle and clears cfg_err.
- R4: A register 0 write that fails the R3 test leaves the fields and read-back unchanged and sets cfg_err. The next accepted write clears cfg_err.
- R5: Register 1 (wr_sel=1) has this layout: select in bit 0, processor ratio code in bits 3:1 and bus ratio code in bits 6:4. Bits 15:7 read 0. A code of 7 in either field rejects the write in the same way as R4. An accepted write clears cfg_err.
- R6: bus_en is a one-cycle pulse every 2^(bus code+2) clk cycles.
- R7: With select = 1, cpu_en is a one-cycle pulse every 2^(cpu code+1) clk cycles. A select change takes effect at the next bus_en pulse.
- R8: With select = 0, cpu_en equals bus_en in every cycle.
- R9: A new ratio code takes effect only after the current divided period has ended. Across a change, every interval between pulses equals either the old ratio or the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pre | input | 5 | Pre-divider strap pins, pulled up when undriven |
| strap_post | input | 2 | Post-divider strap pins, pulled up when undriven |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write register select (0 synthesizer, 1 clock tree) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read register select |
| rd_data | output | 16 | Read data, combinational from rd_sel |
| pre_code | output | 5 | Pre-divider code to the synthesizer |
| mul_code | output | 9 | Multiplier code to the synthesizer |
| post_code | output | 2 | Post-divider code to the synthesizer |
| cpu_en | output | 1 | Processor clock enable pulse |
| bus_en | output | 1 | Bus clock enable pulse |
| cfg_err | output | 1 | Last write was rejected |

## Verification
The field outputs, read-back and cfg_err of a write are due on the cycle after the capturing edge. The strap-loaded fields are due on the cycle after the first edge following reset release. The bench drives on the falling edge and samples on the next falling edge, so each of these results is read exactly one edge after its cause. Enable periods are due only after the running period ends, and a select change only after the next bus pulse. The bench therefore lets 300 cycles pass before it measures a period between two pulses. For the boundary requirement it instead watches every interval continuously while writes land mid-period.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;
   localparam int PRE_W   = 5;
   localparam int MUL_W   = 9;
   localparam int POST_W  = 2;
   localparam int DCODE_W = 3;
   localparam int REG_W   = 16;

   localparam logic [PRE_W-1:0]  PRE_DEF  = 5'd7;
   localparam logic [MUL_W-1:0]  MUL_DEF  = 9'd60;
   localparam logic [POST_W-1:0] POST_DEF = 2'd0;

   // register 0 layout, msb first
   typedef struct packed {
      logic [POST_W-1:0] post;
      logic [MUL_W-1:0]  mul;
      logic [PRE_W-1:0]  pre;
   } synth_cfg_t;

   // register 1 layout, msb first
   typedef struct packed {
      logic [REG_W-2*DCODE_W-2:0] rsv;
      logic [DCODE_W-1:0]         bus;
      logic [DCODE_W-1:0]         cpu;
      logic                       sel;
   } tree_cfg_t;

   // constant-time range rule, used at elaboration to vet defaults
   function automatic bit rate_ok(input longint ref_khz, input longint pfd_lo,
                                  input longint pfd_hi, input longint vco_lo,
                                  input longint vco_hi, input longint pre,
                                  input longint mul);
      longint n;
      longint p;
      n = pre + 1;
      p = ref_khz * (mul + 1);
      return (ref_khz >= pfd_lo * n) && (ref_khz <= pfd_hi * n) &&
             (p >= vco_lo * n) && (p <= vco_hi * n);
   endfunction
endpackage

// File: rtl/clkcfg_range_chk.sv
`timescale 1ns/1ps
module clkcfg_range_chk
   import clkcfg_pkg::*;
#(
   parameter int REF_KHZ     = 29491,
   parameter int PFD_MIN_KHZ = 275,
   parameter int PFD_MAX_KHZ = 550000,
   parameter int VCO_MIN_KHZ = 110000,
   parameter int VCO_MAX_KHZ = 550000
) (
   input  logic [PRE_W-1:0] pre,
   input  logic [MUL_W-1:0] mul,
   output logic             in_range
);
   localparam int PW = 48;
   localparam logic [PW-1:0] REFV  = PW'(REF_KHZ);
   localparam logic [PW-1:0] PFDLO = PW'(PFD_MIN_KHZ);
   localparam logic [PW-1:0] PFDHI = PW'(PFD_MAX_KHZ);
   localparam logic [PW-1:0] VCOLO = PW'(VCO_MIN_KHZ);
   localparam logic [PW-1:0] VCOHI = PW'(VCO_MAX_KHZ);

   if (REF_KHZ <= 0) begin : g_bad_ref
      $error("REF_KHZ must be positive");
   end
   if (PFD_MIN_KHZ > PFD_MAX_KHZ || VCO_MIN_KHZ > VCO_MAX_KHZ) begin : g_bad_lim
      $error("range limits inverted");
   end

   logic [PW-1:0] div_n;
   logic [PW-1:0] mul_n;
   logic [PW-1:0] osc_x;
   logic          pfd_ok;
   logic          osc_ok;

   // cross-multiplied compare: no divider in the write path
   always_comb begin
      div_n  = PW'(pre) + PW'(1);
      mul_n  = PW'(mul) + PW'(1);
      osc_x  = REFV * mul_n;
      pfd_ok = (REFV >= PFDLO * div_n) && (REFV <= PFDHI * div_n);
      osc_ok = (osc_x >= VCOLO * div_n) && (osc_x <= VCOHI * div_n);
      in_range = pfd_ok && osc_ok;
   end
endmodule

// File: rtl/clkcfg_regs.sv
`timescale 1ns/1ps
module clkcfg_regs
   import clkcfg_pkg::*;
#(
   parameter int REF_KHZ     = 29491,
   parameter int PFD_MIN_KHZ = 275,
   parameter int PFD_MAX_KHZ = 550000,
   parameter int VCO_MIN_KHZ = 110000,
   parameter int VCO_MAX_KHZ = 550000,
   parameter int RATIO_STEPS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PRE_W-1:0]    strap_pre,
   input  logic [POST_W-1:0]   strap_post,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic [REG_W-1:0]    wr_data,
   input  logic                rd_sel,
   output logic [REG_W-1:0]    rd_data,
   output synth_cfg_t          synth,
   output logic                sel_req,
   output logic [DCODE_W-1:0]  cpu_code,
   output logic [DCODE_W-1:0]  bus_code,
   output logic                err
);
   localparam logic [DCODE_W-1:0] CODE_MAX = DCODE_W'(RATIO_STEPS - 1);

   if (RATIO_STEPS < 1 || RATIO_STEPS > (1 << DCODE_W)) begin : g_bad_steps
      $error("RATIO_STEPS does not fit the code field");
   end

   synth_cfg_t synth_q;
   tree_cfg_t  tree_q;
   logic       smp_done;
   logic       err_q;
   synth_cfg_t wr_synth;
   tree_cfg_t  wr_tree;
   logic       synth_ok;
   logic       tree_ok;

   assign wr_synth = synth_cfg_t'(wr_data);
   assign wr_tree  = tree_cfg_t'(wr_data);
   assign tree_ok  = (wr_tree.cpu <= CODE_MAX) && (wr_tree.bus <= CODE_MAX);

   clkcfg_range_chk #(
      .REF_KHZ    (REF_KHZ),
      .PFD_MIN_KHZ(PFD_MIN_KHZ),
      .PFD_MAX_KHZ(PFD_MAX_KHZ),
      .VCO_MIN_KHZ(VCO_MIN_KHZ),
      .VCO_MAX_KHZ(VCO_MAX_KHZ)
   ) u_range (
      .pre      (wr_synth.pre),
      .mul      (wr_synth.mul),
      .in_range (synth_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synth_q  <= '{post: POST_DEF, mul: MUL_DEF, pre: PRE_DEF};
         tree_q   <= '0;
         smp_done <= 1'b0;
         err_q    <= 1'b0;
      end else if (!smp_done) begin
         // one-time strap capture; a write in this cycle is dropped
         smp_done     <= 1'b1;
         synth_q.pre  <= PRE_DEF ^ ~strap_pre;
         synth_q.post <= POST_DEF ^ ~strap_post;
      end else if (wr_en) begin
         if (!wr_sel) begin
            if (synth_ok) begin
               synth_q <= wr_synth;
               err_q   <= 1'b0;
            end else begin
               err_q   <= 1'b1;
            end
         end else begin
            if (tree_ok) begin
               tree_q <= '{rsv: '0, bus: wr_tree.bus, cpu: wr_tree.cpu, sel: wr_tree.sel};
               err_q  <= 1'b0;
            end else begin
               err_q  <= 1'b1;
            end
         end
      end
   end

   assign rd_data  = rd_sel ? REG_W'(tree_q) : REG_W'(synth_q);
   assign synth    = synth_q;
   assign sel_req  = tree_q.sel;
   assign cpu_code = tree_q.cpu;
   assign bus_code = tree_q.bus;
   assign err      = err_q;

   // R2
   strap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_done && !(wr_en && !wr_sel)) |=> $stable(synth_q));

   // R3
   accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_done && wr_en && !wr_sel && synth_ok) |=> (synth_q == $past(wr_synth) && !err_q));

   // R4
   reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_done && wr_en && !wr_sel && !synth_ok) |=> ($stable(synth_q) && err_q));

   // R5
   tree_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_done && wr_en && wr_sel && !tree_ok) |=> ($stable(tree_q) && err_q));

   // R5
   tree_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tree_q.rsv == '0);
endmodule

// File: rtl/clkcfg_pow2_div.sv
`timescale 1ns/1ps
module clkcfg_pow2_div #(
   parameter int MIN_LOG = 1,
   parameter int NCODE   = 7,
   parameter int CODE_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_req,
   output logic              tick
);
   localparam int CW = MIN_LOG + NCODE - 1;
   localparam logic [CW:0] ONE = (CW+1)'(1);

   if (MIN_LOG < 1) begin : g_bad_min
      $error("MIN_LOG must be at least 1");
   end
   if (NCODE > (1 << CODE_W)) begin : g_bad_ncode
      $error("NCODE exceeds code width");
   end

   logic [CW-1:0]     cnt;
   logic [CW-1:0]     lim;
   logic [CODE_W-1:0] act;

   // terminal count for ratio 2^(MIN_LOG+act)
   assign lim  = CW'((ONE << (MIN_LOG + int'(act))) - ONE);
   assign tick = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         act <= '0;
      end else if (tick) begin
         cnt <= '0;
         act <= code_req;   // new ratio only at a period boundary
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   // R6
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R9
   ratio_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act) |-> $past(tick));

   // R9
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));
endmodule

// File: rtl/clkcfg_ctrl.sv
`timescale 1ns/1ps
module clkcfg_ctrl
   import clkcfg_pkg::*;
#(
   parameter int REF_KHZ     = 29491,
   parameter int PFD_MIN_KHZ = 275,
   parameter int PFD_MAX_KHZ = 550000,
   parameter int VCO_MIN_KHZ = 110000,
   parameter int VCO_MAX_KHZ = 550000,
   parameter int CPU_MIN_LOG = 1,
   parameter int BUS_MIN_LOG = 2,
   parameter int RATIO_STEPS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRE_W-1:0]  strap_pre,
   input  logic [POST_W-1:0] strap_post,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_sel,
   output logic [REG_W-1:0]  rd_data,
   output logic [PRE_W-1:0]  pre_code,
   output logic [MUL_W-1:0]  mul_code,
   output logic [POST_W-1:0] post_code,
   output logic              cpu_en,
   output logic              bus_en,
   output logic              cfg_err
);
   localparam int NCHAIN = 2;

   if (!rate_ok(REF_KHZ, PFD_MIN_KHZ, PFD_MAX_KHZ, VCO_MIN_KHZ, VCO_MAX_KHZ,
                longint'(PRE_DEF), longint'(MUL_DEF))) begin : g_bad_default
      $error("default synthesizer setting is out of range");
   end

   synth_cfg_t         synth;
   logic               sel_req;
   logic               sel_act;
   logic [DCODE_W-1:0] cpu_code;
   logic [DCODE_W-1:0] bus_code;
   logic [DCODE_W-1:0] req_v [NCHAIN];
   logic [NCHAIN-1:0]  tick_v;

   clkcfg_regs #(
      .REF_KHZ    (REF_KHZ),
      .PFD_MIN_KHZ(PFD_MIN_KHZ),
      .PFD_MAX_KHZ(PFD_MAX_KHZ),
      .VCO_MIN_KHZ(VCO_MIN_KHZ),
      .VCO_MAX_KHZ(VCO_MAX_KHZ),
      .RATIO_STEPS(RATIO_STEPS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_pre (strap_pre),
      .strap_post(strap_post),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .rd_sel    (rd_sel),
      .rd_data   (rd_data),
      .synth     (synth),
      .sel_req   (sel_req),
      .cpu_code  (cpu_code),
      .bus_code  (bus_code),
      .err       (cfg_err)
   );

   assign req_v[0] = cpu_code;
   assign req_v[1] = bus_code;

   // chain 0 feeds the processor side, chain 1 the bus side
   for (genvar gi = 0; gi < NCHAIN; gi++) begin : g_chain
      localparam int ML = (gi == 0) ? CPU_MIN_LOG : BUS_MIN_LOG;
      clkcfg_pow2_div #(
         .MIN_LOG(ML),
         .NCODE  (RATIO_STEPS),
         .CODE_W (DCODE_W)
      ) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .code_req(req_v[gi]),
         .tick    (tick_v[gi])
      );
   end

   // select follows the register only at a bus boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_act <= 1'b0;
      end else if (tick_v[1]) begin
         sel_act <= sel_req;
      end
   end

   assign bus_en    = tick_v[1];
   assign cpu_en    = sel_act ? tick_v[0] : tick_v[1];
   assign pre_code  = synth.pre;
   assign mul_code  = synth.mul;
   assign post_code = synth.post;

   // R7
   sel_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_act) |-> $past(bus_en));

   // R7
   cpu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_en |=> !cpu_en);
endmodule

// File: tb/test_clkcfg_ctrl.sv
`timescale 1ns/1ps
module test_clkcfg_ctrl;
   localparam longint REF = 29491;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  strap_pre;
   logic [1:0]  strap_post;
   logic        wr_en;
   logic        wr_sel;
   logic [15:0] wr_data;
   logic        rd_sel;
   logic [15:0] rd_data;
   logic [4:0]  pre_code;
   logic [8:0]  mul_code;
   logic [1:0]  post_code;
   logic        cpu_en;
   logic        bus_en;
   logic        cfg_err;

   always #10 clk = ~clk;

   clkcfg_ctrl i_clkcfg_ctrl (
      .clk(clk), .rst_n(rst_n), .strap_pre(strap_pre), .strap_post(strap_post),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .pre_code(pre_code), .mul_code(mul_code),
      .post_code(post_code), .cpu_en(cpu_en), .bus_en(bus_en), .cfg_err(cfg_err)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;
   logic [15:0] m_syn;
   logic [15:0] m_clk;
   logic        m_err;

   function automatic bit exp_ok(input logic [15:0] d);
      longint n;
      longint p;
      n = longint'(d[4:0]) + 1;
      p = REF * (longint'(d[13:5]) + 1);
      return (REF >= 275 * n) && (REF <= 550000 * n) &&
             (p >= 110000 * n) && (p <= 550000 * n);
   endfunction

   function automatic logic [15:0] tree_word(input int bus, input int cpu, input bit sel);
      return {9'd0, 3'(bus), 3'(cpu), sel};
   endfunction

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (!sel) begin
         if (exp_ok(d)) begin m_syn = d; m_err = 1'b0; end
         else m_err = 1'b1;
      end else begin
         if (d[3:1] != 3'd7 && d[6:4] != 3'd7) begin m_clk = d & 16'h007f; m_err = 1'b0; end
         else m_err = 1'b1;
      end
   endtask

   task automatic check_cfg(input string req);
      chk(req, "pre_code", pre_code, m_syn[4:0]);
      chk(req, "mul_code", mul_code, m_syn[13:5]);
      chk(req, "post_code", post_code, m_syn[15:14]);
      chk(req, "cfg_err", cfg_err, m_err);
      rd_sel = 1'b0; #1;
      chk(req, "read reg0", rd_data, m_syn);
      rd_sel = 1'b1; #1;
      chk(req, "read reg1", rd_data, m_clk);
   endtask

   task automatic get_period(input bit use_cpu, output int per);
      int c;
      c = 0;
      do @(negedge clk); while (!(use_cpu ? cpu_en : bus_en));
      do begin @(negedge clk); c++; end while (!(use_cpu ? cpu_en : bus_en));
      per = c;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog (all requirements): actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      int per;
      int mism;
      int last;
      int bad;
      logic [15:0] d;
      void'($urandom(32'd1234));
      rst_n = 1'b0; strap_pre = 5'b10101; strap_post = 2'b01;
      wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      m_syn = {2'd0, 9'd60, 5'd7}; m_clk = '0; m_err = 1'b0;
      check_cfg("R1");
      chk("R1", "bus_en", bus_en, 0);
      chk("R1", "cpu_en", cpu_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 strap capture on first edge
      m_syn = {2'd0 ^ ~2'b01, 9'd60, 5'd7 ^ ~5'b10101};
      check_cfg("R2");
      strap_pre = 5'b00000; strap_post = 2'b10;
      repeat (5) @(negedge clk);
      check_cfg("R2");

      // R3 / R4 directed
      wr(1'b0, {2'd1, 9'd60, 5'd7});  check_cfg("R3");
      wr(1'b0, {2'd0, 9'd10, 5'd7});  check_cfg("R4");
      wr(1'b0, {2'd0, 9'd3, 5'd0});   check_cfg("R3");
      wr(1'b0, {2'd0, 9'd2, 5'd0});   check_cfg("R4");
      wr(1'b0, {2'd3, 9'd20, 5'd0});  check_cfg("R4");
      wr(1'b0, {2'd2, 9'd60, 5'd31}); check_cfg("R4");
      wr(1'b0, {2'd0, 9'd60, 5'd7});  check_cfg("R4");
      for (int i = 0; i < 40; i++) begin
         d = 16'($urandom);
         if (i % 2 == 1) d = {d[15:14], 9'(3 + $urandom % 120), 5'($urandom % 8)};
         wr(1'b0, d);
         check_cfg("R3");
      end

      // R5 tree register
      wr(1'b1, tree_word(0, 7, 1'b1)); check_cfg("R5");
      wr(1'b1, tree_word(7, 0, 1'b0)); check_cfg("R5");
      wr(1'b1, 16'hff80 | tree_word(2, 3, 1'b0)); check_cfg("R5");

      // R6 bus ratios
      for (int c = 0; c < 7; c++) begin
         wr(1'b1, tree_word(c, 0, 1'b0));
         repeat (300) @(negedge clk);
         get_period(1'b0, per);
         chk("R6", "bus period", per, 1 << (c + 2));
      end

      // R7 processor ratios with select set
      for (int c = 0; c < 7; c++) begin
         wr(1'b1, tree_word(2, c, 1'b1));
         repeat (300) @(negedge clk);
         get_period(1'b1, per);
         chk("R7", "cpu period", per, 1 << (c + 1));
      end

      // R8 select clear: processor follows bus
      wr(1'b1, tree_word(1, 4, 1'b0));
      repeat (300) @(negedge clk);
      mism = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (cpu_en !== bus_en) mism++;
      end
      chk("R8", "cpu/bus mismatches", mism, 0);
      get_period(1'b1, per);
      chk("R8", "cpu period", per, 8);

      // R9 ratio changes land mid-period
      wr(1'b1, tree_word(1, 0, 1'b0));
      repeat (300) @(negedge clk);
      last = -1; bad = 0; per = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (bus_en) begin
            if (last >= 0) begin
               per = i - last;
               if (per != 8 && per != 32) bad++;
            end
            last = i;
         end
         if (i == 103) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = tree_word(3, 0, 1'b0); end
         if (i == 104) wr_en = 1'b0;
         if (i == 317) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = tree_word(1, 0, 1'b0); end
         if (i == 318) wr_en = 1'b0;
      end
      m_clk = tree_word(1, 0, 1'b0);
      chk("R9", "odd intervals", bad, 0);
      chk("R9", "final interval", per, 8);

      finished = 1;
      summary();
      $finish;
   end
endmodule